// File: doc/BRIEF.md
# UART Receive Buffer with Line Status

This block sits between the bit-level receiver of a serial port and the CPU. Each time the receiver finishes a character it strobes the byte in together with its framing and parity flags. The block stores the byte in a 16-entry FIFO, and every entry carries its own error tags. A separate detector watches the raw line level against a bit-time tick and the programmed frame length. When the line stays low for longer than a whole frame, it tags the next stored character as a break.

The CPU sees a status byte and one interrupt line. The break, framing and parity indications describe only the character at the FIFO head, so the CPU can read status and data in order. Overrun shows up in the same cycle it is recorded. A status read acknowledges the current head's tags and clears overrun. A status write does nothing.

Two state machines shape the behaviour. The break detector has the states BRK_IDLE, BRK_COUNT and BRK_HELD:
- BRK_IDLE goes to BRK_COUNT when the line goes low.
- BRK_COUNT goes back to BRK_IDLE when the line goes high.
- BRK_COUNT goes to BRK_HELD on the tick that pushes the low time past the frame length. That transition fires the break pulse.
- BRK_HELD goes to BRK_IDLE when the line goes high.

The head-status machine has the states HEAD_EMPTY, HEAD_SHOWN and HEAD_ACKED:
- Any change of head entry leads to HEAD_SHOWN.
- Popping the last entry leads to HEAD_EMPTY.
- A status read in HEAD_SHOWN leads to HEAD_ACKED.

Top module: `uart_rx_status`

## Requirements
- R1: The status byte places break at bit 3, framing error at bit 4, parity error at bit 5, overrun at bit 6 and data-ready at bit 7. Bits 2 to 0 always read 0, and after reset the whole byte and the interrupt are 0.
- R2: Data-ready is 1 from the cycle after a character is stored and stays 1 while the FIFO holds at least one entry. It returns to 0 in the cycle after the last entry is popped.
- R3: The FIFO holds 16 characters in arrival order, and `rx_data` shows the head entry. A pop strobe on an empty FIFO has no effect.
- R4: The break, framing and parity bits reflect only the tags of the current head entry. They appear in the cycle after that entry becomes the head.
- R5: A status read clears the break, framing and parity bits for the current head. When a new entry becomes head, its tags show, even if a read happens in that same cycle.
- R6: A character completed while the FIFO holds 16 entries is discarded, and the stored contents are unchanged. This holds even when a pop happens in the same cycle. The overrun bit is 1 in the next cycle.
- R7: A status read clears the overrun bit, unless a new overrun occurs in the same cycle.
- R8: If the line stays low for more than `frame_bits` bit ticks, the next stored character is tagged as a break. A low period of `frame_bits` ticks or fewer tags nothing.
- R9: `irq_rls` is 1 exactly when `ie_rls` is 1 and at least one of status bits 3 to 6 is 1.
- R10: After a status read in a cycle with no character strobe and no pop, `irq_rls` is 0.
- R11: A status write strobe changes neither the status byte nor the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_done | input | 1 | One-cycle strobe: a character has been received |
| char_data | input | 8 | Received data byte |
| char_ferr | input | 1 | Stop position sampled as 0 for this character |
| char_perr | input | 1 | Parity check failed for this character |
| line_in | input | 1 | Current serial line level |
| bit_tick | input | 1 | One pulse per bit time |
| frame_bits | input | 4 | Frame length in bit times (start, data, parity, stop), at least 1 |
| rbr_pop | input | 1 | CPU read of the receive buffer; removes the head |
| lsr_rd | input | 1 | CPU read of the status byte |
| lsr_wr | input | 1 | CPU write of the status byte (ignored) |
| ie_rls | input | 1 | Enable for the receiver-line-status interrupt |
| rx_data | output | 8 | Data of the head entry |
| lsr | output | 8 | Status byte |
| irq_rls | output | 1 | Receiver-line-status interrupt |

## Verification
The directed patterns use one character at a time with a framing or parity tag. They show that a tag follows its own entry to the head and does not leak onto the status of the entry in front of it. A full FIFO with one more strobe, issued alone, with a pop and with a read, separates discard-without-overwrite from a real overwrite. It also shows whether a read wins over a new overrun. Break runs of exactly `frame_bits` and `frame_bits`+1 ticked low cycles mark the boundary of the detector. Long constrained-random runs overlap strobes, reads, pops and low bursts, and catch ordering errors where a clear and a new event land in the same cycle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int RX_DATA_W = 8;

    localparam int LSR_BI = 3;
    localparam int LSR_FE = 4;
    localparam int LSR_PE = 5;
    localparam int LSR_OE = 6;
    localparam int LSR_DR = 7;

    typedef struct packed {
        logic                 brk;
        logic                 ferr;
        logic                 perr;
        logic [RX_DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        BRK_IDLE  = 2'd0,
        BRK_COUNT = 2'd1,
        BRK_HELD  = 2'd2
    } brk_state_t;

    typedef enum logic [1:0] {
        HEAD_EMPTY = 2'd0,
        HEAD_SHOWN = 2'd1,
        HEAD_ACKED = 2'd2
    } head_state_t;

endpackage

// File: rtl/uart_rx_brkdet.sv
module uart_rx_brkdet #(
    parameter int FRAME_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_in,
    input  logic               bit_tick,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               brk_pulse
);
    import uart_rx_pkg::*;

    brk_state_t         st_q, st_d;
    logic [FRAME_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BRK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: low time counted in bit ticks
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            BRK_IDLE: begin
                if (!line_in) begin
                    st_d  = BRK_COUNT;
                    cnt_d = FRAME_W'(bit_tick);
                end
            end
            BRK_COUNT: begin
                if (line_in) begin
                    st_d = BRK_IDLE;
                end else if (bit_tick) begin
                    if (cnt_q == frame_bits) st_d = BRK_HELD;
                    else                     cnt_d = cnt_q + 1'b1;
                end
            end
            BRK_HELD: begin
                if (line_in) st_d = BRK_IDLE;
            end
            default: st_d = BRK_IDLE;
        endcase
    end

    // outputs: one pulse on the tick that exceeds the frame
    always_comb begin
        brk_pulse = (st_q == BRK_COUNT) && !line_in && bit_tick
                    && (cnt_q == frame_bits);
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  uart_rx_pkg::rx_entry_t wr_entry,
    input  logic                  pop,
    output uart_rx_pkg::rx_entry_t head,
    output logic                  empty,
    output logic                  full,
    output logic                  single
);
    import uart_rx_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   CNT_MAX = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == PTR_MAX) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head   = mem[rd_ptr];
    assign empty  = (count == '0);
    assign full   = (count == CNT_MAX);
    assign single = (count == (AW+1)'(1));

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   head_change,
    input  logic                   go_empty,
    input  logic                   rd_acc,
    input  logic                   ovr_evt,
    input  logic                   ie_rls,
    input  logic                   not_empty,
    input  uart_rx_pkg::rx_entry_t head,
    output logic [7:0]             lsr,
    output logic                   irq_rls
);
    import uart_rx_pkg::*;

    head_state_t hs_q, hs_d;
    logic        oe_q;

    // state register and overrun flag (new event beats the clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= HEAD_EMPTY;
            oe_q <= 1'b0;
        end else begin
            hs_q <= hs_d;
            if (ovr_evt)     oe_q <= 1'b1;
            else if (rd_acc) oe_q <= 1'b0;
        end
    end

    // next state: a new head always wins over an acknowledge
    always_comb begin
        hs_d = hs_q;
        unique case (hs_q)
            HEAD_EMPTY: begin
                if (head_change) hs_d = HEAD_SHOWN;
            end
            HEAD_SHOWN: begin
                if (head_change)   hs_d = HEAD_SHOWN;
                else if (go_empty) hs_d = HEAD_EMPTY;
                else if (rd_acc)   hs_d = HEAD_ACKED;
            end
            HEAD_ACKED: begin
                if (head_change)   hs_d = HEAD_SHOWN;
                else if (go_empty) hs_d = HEAD_EMPTY;
            end
            default: hs_d = HEAD_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        logic show;
        show        = (hs_q == HEAD_SHOWN);
        lsr         = '0;
        lsr[LSR_BI] = show & head.brk;
        lsr[LSR_FE] = show & head.ferr;
        lsr[LSR_PE] = show & head.perr;
        lsr[LSR_OE] = oe_q;
        lsr[LSR_DR] = not_empty;
        irq_rls     = ie_rls & (|lsr[LSR_OE:LSR_BI]);
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
    parameter int FIFO_DEPTH = 16,
    parameter int FRAME_W    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              char_done,
    input  logic [uart_rx_pkg::RX_DATA_W-1:0] char_data,
    input  logic                              char_ferr,
    input  logic                              char_perr,
    input  logic                              line_in,
    input  logic                              bit_tick,
    input  logic [FRAME_W-1:0]                frame_bits,
    input  logic                              rbr_pop,
    input  logic                              lsr_rd,
    input  logic                              lsr_wr,
    input  logic                              ie_rls,
    output logic [uart_rx_pkg::RX_DATA_W-1:0] rx_data,
    output logic [7:0]                        lsr,
    output logic                              irq_rls
);
    import uart_rx_pkg::*;

    logic      fifo_empty, fifo_full, fifo_single;
    logic      brk_pulse, brk_pend;
    logic      do_push, do_pop, ovr_evt, head_change, go_empty;
    logic      lsr_wr_unused;
    rx_entry_t new_entry, head_entry;

    // status writes are accepted and dropped
    assign lsr_wr_unused = lsr_wr;

    assign do_push     = char_done & ~fifo_full;
    assign ovr_evt     = char_done &  fifo_full;
    assign do_pop      = rbr_pop   & ~fifo_empty;
    assign head_change = (do_push & fifo_empty) | (do_pop & (~fifo_single | do_push));
    assign go_empty    = do_pop & fifo_single & ~do_push;

    always_comb begin
        new_entry.brk  = brk_pulse | brk_pend;
        new_entry.ferr = char_ferr;
        new_entry.perr = char_perr;
        new_entry.data = char_data;
    end

    // a detected break waits for the next stored character
    always_ff @(posedge clk) begin
        if (!rst_n)         brk_pend <= 1'b0;
        else if (do_push)   brk_pend <= 1'b0;
        else if (brk_pulse) brk_pend <= 1'b1;
    end

    uart_rx_brkdet #(.FRAME_W(FRAME_W)) u_brkdet (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .bit_tick   (bit_tick),
        .frame_bits (frame_bits),
        .brk_pulse  (brk_pulse)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .wr_entry (new_entry),
        .pop      (do_pop),
        .head     (head_entry),
        .empty    (fifo_empty),
        .full     (fifo_full),
        .single   (fifo_single)
    );

    uart_rx_lsr u_lsr (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_change (head_change),
        .go_empty    (go_empty),
        .rd_acc      (lsr_rd),
        .ovr_evt     (ovr_evt),
        .ie_rls      (ie_rls),
        .not_empty   (~fifo_empty),
        .head        (head_entry),
        .lsr         (lsr),
        .irq_rls     (irq_rls)
    );

    assign rx_data = head_entry.data;

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       char_done,
    input logic       rbr_pop,
    input logic       lsr_rd,
    input logic       lsr_wr,
    input logic       ie_rls,
    input logic       fifo_full,
    input logic [7:0] rx_data,
    input logic [7:0] lsr,
    input logic       irq_rls
);

    // R6: overflow keeps the head and flags overrun next cycle
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && fifo_full && !rbr_pop) |=> ($stable(rx_data) && lsr[6]));

    // R7: read clears overrun unless a new one lands
    a_r7_read_clears_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !(char_done && fifo_full)) |=> !lsr[6]);

    // R2: any strobe leaves the FIFO non-empty
    a_r2_strobe_sets_dr: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> lsr[7]);

    // R9: no interrupt while disabled
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_rls |-> !irq_rls);

    // R10: a quiet read drops the interrupt
    a_r10_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !char_done && !rbr_pop) |=> !irq_rls);

    // R11: a write alone leaves status untouched
    a_r11_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_wr && !lsr_rd && !char_done && !rbr_pop) |=> $stable(lsr));

endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_done (char_done),
    .rbr_pop   (rbr_pop),
    .lsr_rd    (lsr_rd),
    .lsr_wr    (lsr_wr),
    .ie_rls    (ie_rls),
    .fifo_full (fifo_full),
    .rx_data   (rx_data),
    .lsr       (lsr),
    .irq_rls   (irq_rls)
);

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_done = 0, char_ferr = 0, char_perr = 0;
    logic [7:0] char_data = 0;
    logic       line_in = 1, bit_tick = 0;
    logic [3:0] frame_bits = 4'd4;
    logic       rbr_pop = 0, lsr_rd = 0, lsr_wr = 0, ie_rls = 1;
    logic [7:0] rx_data, lsr;
    logic       irq_rls;

    always #2.5 clk = ~clk;

    uart_rx_status u_uart_rx_status (
        .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
        .char_ferr(char_ferr), .char_perr(char_perr), .line_in(line_in),
        .bit_tick(bit_tick), .frame_bits(frame_bits), .rbr_pop(rbr_pop),
        .lsr_rd(lsr_rd), .lsr_wr(lsr_wr), .ie_rls(ie_rls),
        .rx_data(rx_data), .lsr(lsr), .irq_rls(irq_rls)
    );

    int n_chk = 0, n_fail = 0;

    // reference state: entry = {brk, ferr, perr, data}
    logic [10:0] mq[$];
    bit m_ack = 0, m_oe = 0, m_pend = 0, m_fired = 0;
    int m_low = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int sz = mq.size();
        bit full = (sz == 16), empty = (sz == 0);
        bit fire = 0, push, ovr, pop, hc;
        logic [10:0] ent;
        if (line_in) begin
            m_low = 0; m_fired = 0;
        end else if (bit_tick && !m_fired) begin
            if (m_low == int'(frame_bits)) begin fire = 1; m_fired = 1; end
            else m_low++;
        end
        push = char_done && !full;
        ovr  = char_done && full;
        pop  = rbr_pop && !empty;
        hc   = (push && empty) || (pop && (sz > 1 || push));
        if (hc) m_ack = 0; else if (lsr_rd) m_ack = 1;
        if (ovr) m_oe = 1; else if (lsr_rd) m_oe = 0;
        ent = {fire | m_pend, char_ferr, char_perr, char_data};
        if (push) m_pend = 0; else if (fire) m_pend = 1;
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back(ent);
    endtask

    task automatic compare_all();
        bit [7:0] exp_lsr = 8'h00;
        if (mq.size() > 0) begin
            exp_lsr[7] = 1;
            exp_lsr[3] = mq[0][10] & !m_ack;
            exp_lsr[4] = mq[0][9]  & !m_ack;
            exp_lsr[5] = mq[0][8]  & !m_ack;
            chk("R3", "rx_data", rx_data, mq[0][7:0]);
        end
        exp_lsr[6] = m_oe;
        chk("R1", "low bits", lsr[2:0], 0);
        chk("R2", "data ready", lsr[7], exp_lsr[7]);
        chk("R8", "break bit", lsr[3], exp_lsr[3]);
        chk("R4", "framing bit", lsr[4], exp_lsr[4]);
        chk("R5", "parity bit", lsr[5], exp_lsr[5]);
        chk("R6", "overrun bit", lsr[6], exp_lsr[6]);
        chk("R9", "irq", irq_rls, int'(ie_rls && (|exp_lsr[6:3])));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_in();
        char_done = 0; char_ferr = 0; char_perr = 0;
        rbr_pop = 0; lsr_rd = 0; lsr_wr = 0;
    endtask

    task automatic push_char(logic [7:0] d, logic f, logic p);
        char_done = 1; char_data = d; char_ferr = f; char_perr = p;
        cyc(); idle_in();
    endtask

    task automatic do_pop();  rbr_pop = 1; cyc(); idle_in(); endtask
    task automatic do_read(); lsr_rd  = 1; cyc(); idle_in(); endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1", "reset lsr", lsr, 8'h00);
        chk("R1", "reset irq", irq_rls, 0);

        do_pop();                                   // R3: pop on empty
        chk("R3", "empty pop", lsr, 8'h00);

        push_char(8'hA5, 1, 0);
        chk("R4", "fe at head", lsr, 8'h90);
        chk("R9", "irq with fe", irq_rls, 1);
        push_char(8'h3C, 0, 1);
        chk("R4", "pe hidden behind head", lsr, 8'h90);
        chk("R3", "head kept", rx_data, 8'hA5);
        lsr_wr = 1; cyc(); idle_in();
        chk("R11", "write ignored", lsr, 8'h90);
        do_read();
        chk("R5", "read clears fe", lsr, 8'h80);
        chk("R10", "read clears irq", irq_rls, 0);
        do_pop();
        chk("R4", "next head pe", lsr, 8'hA0);
        chk("R3", "order", rx_data, 8'h3C);
        lsr_rd = 1; rbr_pop = 1; cyc(); idle_in();
        chk("R2", "last pop", lsr, 8'h00);

        ie_rls = 0;
        push_char(8'h55, 1, 1);
        chk("R9", "irq disabled", irq_rls, 0);
        ie_rls = 1;
        do_read(); do_pop();

        for (int i = 0; i < 16; i++) push_char(8'(i), 0, 0);
        push_char(8'hEE, 1, 1);
        chk("R6", "overrun flag", lsr[6], 1);
        chk("R6", "head intact", rx_data, 8'h00);
        char_done = 1; char_data = 8'hEF; rbr_pop = 1; cyc(); idle_in();
        chk("R6", "overrun with pop", rx_data, 8'h01);
        lsr_rd = 1; char_done = 1; char_data = 8'hF0; cyc(); idle_in();
        chk("R6", "no room after pop? no, refill", lsr[7], 1);
        do_read();
        chk("R7", "overrun cleared", lsr[6], 0);
        while (lsr[7]) do_pop();
        chk("R2", "drained", lsr, 8'h00);

        // R8: break boundary, frame_bits = 4
        bit_tick = 1; line_in = 0;
        repeat (5) cyc();
        line_in = 1; cyc();
        push_char(8'h00, 1, 0);
        chk("R8", "break tagged", lsr, 8'h98);
        do_read(); do_pop();
        line_in = 0;
        repeat (4) cyc();
        line_in = 1; cyc();
        push_char(8'h11, 0, 0);
        chk("R8", "short low no break", lsr, 8'h80);
        do_pop();
        bit_tick = 0;

        // random phase
        frame_bits = 4'd6;
        begin
            int low_left = 0;
            for (int c = 0; c < 6000; c++) begin
                int pop_div = (c < 1500) ? 9 : 3;
                char_done = ($urandom % 3) == 0;
                char_data = 8'($urandom);
                char_ferr = ($urandom % 5) == 0;
                char_perr = ($urandom % 5) == 0;
                rbr_pop   = ($urandom % pop_div) == 0;
                lsr_rd    = ($urandom % 4) == 0;
                lsr_wr    = ($urandom % 6) == 0;
                ie_rls    = ($urandom % 8) != 0;
                bit_tick  = ($urandom % 2) == 0;
                if (low_left > 0) low_left--;
                else if (($urandom % 60) == 0) low_left = 4 + ($urandom % 24);
                line_in = (low_left == 0);
                cyc();
            end
        end
        idle_in(); line_in = 1;
        cyc();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule